// File: doc/BRIEF.md
# Dual-Bank Byte-Lane Access Sequencer

This block sits between a requester that thinks in bytes and 16-bit words at arbitrary byte addresses and a memory bus whose data path is split into two 8-bit banks. The even bank answers on data bits 7:0 and the odd bank on bits 15:8. Each bank is addressed by the upper address bits. Two strobes select which lane is live in a bus cycle: an active-low high-lane enable and address bit 0. The sequencer turns each request into one or two bus cycles. It routes write bytes onto the correct lane, collects read bytes from the correct lane, and reports completion with a single done pulse.

A word at an even address moves in one cycle on both lanes. A word at an odd address straddles the two banks, so the sequencer splits it into two back-to-back byte cycles. The first cycle moves the low byte on the high lane at the odd address. The second cycle moves the high byte on the low lane at the following even address. The requester sees only the extra latency, and read data arrives already assembled in little-endian order. Every bus cycle is held until the memory side raises a ready input.

Top module: `lane_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, `busy`, `done` and `bus_cyc` are all low.
- R2: A byte access at an even address uses one bus cycle with `bus_addr` = address bits 19:1 and {`bus_bhe_n`,`bus_a0`} = 2'b10. Write data goes on bits 7:0 and bits 15:8 are driven to zero.
- R3: A byte access at an odd address uses one bus cycle with {`bus_bhe_n`,`bus_a0`} = 2'b01. Write data goes on bits 15:8 and bits 7:0 are driven to zero.
- R4: A word access at an even address uses one bus cycle with {`bus_bhe_n`,`bus_a0`} = 2'b00. The word's low byte is on bits 7:0 and its high byte on bits 15:8.
- R5: A word access at an odd address N uses two consecutive bus cycles with no idle cycle between them. The first cycle is at N with enables 2'b01 and the low byte on bits 15:8. The second cycle is at N+1 with enables 2'b10 and the high byte on bits 7:0.
- R6: For an odd word at the last byte address, the second cycle's address wraps to zero.
- R7: During a bus cycle, {`bus_bhe_n`,`bus_a0`} is never 2'b11.
- R8: A bus cycle keeps its address, enables, direction and write data unchanged until `bus_ready` is sampled high at a clock edge, and it ends at that edge.
- R9: `done` is high for exactly one cycle, in the cycle after the ready edge of the final bus cycle, and never between the two halves of a split word.
- R10: On `done` after a read, `rdata` holds the result. A byte read gives the byte in bits 7:0 with bits 15:8 zero. A word read gives the lower-address byte in bits 7:0 and the higher-address byte in bits 15:8.
- R11: A `req_valid` raised while `busy` is high is ignored and starts no bus cycle.
- R12: `bus_we` equals the request's write flag in every bus cycle of that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a transfer (taken only while idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 16 | Write data (byte in bits 7:0) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Assembled read data |
| bus_cyc | output | 1 | Bus cycle active |
| bus_we | output | 1 | Bus cycle direction |
| bus_addr | output | 19 | Bank address (byte address bits 19:1) |
| bus_bhe_n | output | 1 | Active-low high-lane enable |
| bus_a0 | output | 1 | Address bit 0 / low-lane disable |
| bus_wdata | output | 16 | Lane-steered write data |
| bus_rdata | input | 16 | Read data from both banks |
| bus_ready | input | 1 | Ends the current bus cycle |

## Verification
The bench covers every combination of size, direction and address parity, with different numbers of wait states, and it checks each bus cycle's address, enables and lane data. Split words are the main target. A design that swaps lanes or swaps the cycle order would return byte-swapped read data. One that forgets to carry into bit 1 would reissue the odd address. One that inserts a gap or raises done after the first half would show that on `bus_cyc` and `done`. The odd word at the top of the address space checks that the second cycle wraps to zero. A request raised during a transfer must leave no trace on the bus.

// File: rtl/lane_pkg.sv
package lane_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned LANES  = 2;
   localparam int unsigned DATA_W = BYTE_W * LANES;

   // {bhe_n, a0} as driven on the bus
   typedef enum logic [1:0] {
      LANE_BOTH = 2'b00,
      LANE_HI   = 2'b01,
      LANE_LO   = 2'b10
   } lane_sel_t;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_BUS  = 1'b1
   } seq_state_t;
endpackage

// File: rtl/lane_plan.sv
module lane_plan
   import lane_pkg::*;
#(
   parameter int unsigned ADDR_W = 20
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              word,
   input  logic              second,
   output logic [ADDR_W-2:0] bus_addr,
   output lane_sel_t         lane,
   output logic              last
);
   logic [ADDR_W-1:0] cur_addr;

   always_comb begin
      cur_addr = second ? addr + 1'b1 : addr;
      bus_addr = cur_addr[ADDR_W-1:1];
      if (!word) begin
         lane = addr[0] ? LANE_HI : LANE_LO;
         last = 1'b1;
      end else if (!addr[0]) begin
         lane = LANE_BOTH;
         last = 1'b1;
      end else if (!second) begin
         lane = LANE_HI;
         last = 1'b0;
      end else begin
         lane = LANE_LO;
         last = 1'b1;
      end
   end
endmodule

// File: rtl/lane_steer.sv
module lane_steer
   import lane_pkg::*;
#(
   parameter bit LANE_FILL = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  lane_sel_t         lane,
   input  logic              word,
   input  logic              second,
   input  logic              last,
   input  logic              cap_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [BYTE_W-1:0] tx_byte;
   logic [BYTE_W-1:0] fill_byte;
   logic [BYTE_W-1:0] rx_byte;
   logic [BYTE_W-1:0] lo_q;
   logic [DATA_W-1:0] rdata_q;

   assign tx_byte = (word && second) ? wdata[DATA_W-1:BYTE_W] : wdata[BYTE_W-1:0];

   generate
      if (LANE_FILL) begin : g_fill_copy
         assign fill_byte = tx_byte;
      end else begin : g_fill_zero
         assign fill_byte = '0;
      end
   endgenerate

   always_comb begin
      case (lane)
         LANE_LO: bus_wdata = {fill_byte, tx_byte};
         LANE_HI: bus_wdata = {tx_byte, fill_byte};
         default: bus_wdata = wdata;
      endcase
   end

   assign rx_byte = (lane == LANE_HI) ? bus_rdata[DATA_W-1:BYTE_W]
                                      : bus_rdata[BYTE_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q    <= '0;
         rdata_q <= '0;
      end else if (cap_en) begin
         if (!last) begin
            lo_q <= rx_byte;
         end else if (lane == LANE_BOTH) begin
            rdata_q <= bus_rdata;
         end else if (word) begin
            rdata_q <= {rx_byte, lo_q};
         end else begin
            rdata_q <= {{BYTE_W{1'b0}}, rx_byte};
         end
      end
   end

   assign rdata = rdata_q;
endmodule

// File: rtl/lane_ctl.sv
module lane_ctl
   import lane_pkg::*;
#(
   parameter int unsigned ADDR_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_word,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              bus_ready,
   input  logic              last,
   output logic [ADDR_W-1:0] addr_q,
   output logic              word_q,
   output logic              write_q,
   output logic              second_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic              active,
   output logic              step,
   output logic              done_q
);
   seq_state_t state_q;

   assign active = (state_q == ST_BUS);
   assign step   = active && bus_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         addr_q   <= '0;
         word_q   <= 1'b0;
         write_q  <= 1'b0;
         second_q <= 1'b0;
         wdata_q  <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  state_q  <= ST_BUS;
                  addr_q   <= req_addr;
                  word_q   <= req_word;
                  write_q  <= req_write;
                  wdata_q  <= req_wdata;
                  second_q <= 1'b0;
               end
            end
            default: begin
               if (bus_ready) begin
                  if (last) begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                  end else begin
                     second_q <= 1'b1;
                  end
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/lane_seq.sv
module lane_seq
   import lane_pkg::*;
#(
   parameter int unsigned ADDR_W    = 20,
   parameter bit          LANE_FILL = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_word,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [15:0]       req_wdata,
   output logic              busy,
   output logic              done,
   output logic [15:0]       rdata,
   output logic              bus_cyc,
   output logic              bus_we,
   output logic [ADDR_W-2:0] bus_addr,
   output logic              bus_bhe_n,
   output logic              bus_a0,
   output logic [15:0]       bus_wdata,
   input  logic [15:0]       bus_rdata,
   input  logic              bus_ready
);
   generate
      if (ADDR_W < 2 || ADDR_W > 32) begin : g_bad_addr_w
         $error("lane_seq: ADDR_W must lie in 2..32");
      end
      if (DATA_W != 16) begin : g_bad_data_w
         $error("lane_seq: data path must be two 8-bit lanes");
      end
   endgenerate

   logic [ADDR_W-1:0] addr_q;
   logic              word_q;
   logic              write_q;
   logic              second_q;
   logic [DATA_W-1:0] wdata_q;
   logic              active;
   logic              step;
   logic              done_q;
   logic              last;
   lane_sel_t         lane;

   lane_ctl #(.ADDR_W(ADDR_W)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_word  (req_word),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .bus_ready (bus_ready),
      .last      (last),
      .addr_q    (addr_q),
      .word_q    (word_q),
      .write_q   (write_q),
      .second_q  (second_q),
      .wdata_q   (wdata_q),
      .active    (active),
      .step      (step),
      .done_q    (done_q)
   );

   lane_plan #(.ADDR_W(ADDR_W)) u_plan (
      .addr     (addr_q),
      .word     (word_q),
      .second   (second_q),
      .bus_addr (bus_addr),
      .lane     (lane),
      .last     (last)
   );

   lane_steer #(.LANE_FILL(LANE_FILL)) u_steer (
      .clk       (clk),
      .rst_n     (rst_n),
      .lane      (lane),
      .word      (word_q),
      .second    (second_q),
      .last      (last),
      .cap_en    (step && !write_q),
      .wdata     (wdata_q),
      .bus_rdata (bus_rdata),
      .bus_wdata (bus_wdata),
      .rdata     (rdata)
   );

   assign busy      = active;
   assign done      = done_q;
   assign bus_cyc   = active;
   assign bus_we    = write_q;
   assign bus_bhe_n = lane[1];
   assign bus_a0    = lane[0];
endmodule

// File: rtl/lane_seq_chk.sv
module lane_seq_chk #(
   parameter int unsigned ADDR_W = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              busy,
   input logic              done,
   input logic              bus_cyc,
   input logic              bus_we,
   input logic [ADDR_W-2:0] bus_addr,
   input logic              bus_bhe_n,
   input logic              bus_a0,
   input logic [15:0]       bus_wdata,
   input logic              bus_ready,
   input logic              word_q
);
   // R7
   enc_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_cyc |-> !(bus_bhe_n && bus_a0));

   // R8
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cyc && !bus_ready) |=> (bus_cyc && $stable(bus_addr) && $stable(bus_bhe_n)
                                   && $stable(bus_a0) && $stable(bus_we) && $stable(bus_wdata)));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   done_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(bus_cyc && bus_ready));

   // R5
   split_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cyc && bus_ready && word_q && !bus_bhe_n && bus_a0)
      |=> (bus_cyc && bus_bhe_n && !bus_a0 && !done
           && bus_addr == $past(bus_addr) + 1'b1));

   // R11
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && req_valid && bus_cyc && !bus_ready) |=> $stable(bus_addr));
endmodule

bind lane_seq lane_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .busy      (busy),
   .done      (done),
   .bus_cyc   (bus_cyc),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_bhe_n (bus_bhe_n),
   .bus_a0    (bus_a0),
   .bus_wdata (bus_wdata),
   .bus_ready (bus_ready),
   .word_q    (word_q)
);

// File: tb/lane_seq_tb.sv
`timescale 1ns/1ps
module lane_seq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic        req_word = 1'b0;
   logic [19:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        busy;
   logic        done;
   logic [15:0] rdata;
   logic        bus_cyc;
   logic        bus_we;
   logic [18:0] bus_addr;
   logic        bus_bhe_n;
   logic        bus_a0;
   logic [15:0] bus_wdata;
   logic [15:0] bus_rdata = '0;
   logic        bus_ready = 1'b0;

   always #2 clk = ~clk;

   lane_seq u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_word  (req_word),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .busy      (busy),
      .done      (done),
      .rdata     (rdata),
      .bus_cyc   (bus_cyc),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_bhe_n (bus_bhe_n),
      .bus_a0    (bus_a0),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .bus_ready (bus_ready)
   );

   typedef struct packed {
      logic        wr;
      logic        wd;
      logic [19:0] addr;
      logic [15:0] wdata;
      logic [1:0]  waits;
      logic [15:0] rd1;
      logic [15:0] rd2;
      logic        two;
      logic [18:0] ea1;
      logic [1:0]  el1;
      logic [15:0] ew1;
      logic [18:0] ea2;
      logic [1:0]  el2;
      logic [15:0] ew2;
      logic [15:0] erd;
   } vec_t;

   localparam vec_t VECS [10] = '{
      '{1'b0,1'b0,20'h12344,16'h0000,2'd0,16'hA55A,16'h0000,1'b0,19'h091A2,2'b10,16'h0000,19'h00000,2'b00,16'h0000,16'h005A},
      '{1'b1,1'b0,20'h12345,16'hBEEF,2'd1,16'h0000,16'h0000,1'b0,19'h091A2,2'b01,16'hEF00,19'h00000,2'b00,16'h0000,16'h0000},
      '{1'b1,1'b0,20'h00010,16'h1234,2'd2,16'h0000,16'h0000,1'b0,19'h00008,2'b10,16'h0034,19'h00000,2'b00,16'h0000,16'h0000},
      '{1'b0,1'b0,20'h00011,16'h0000,2'd0,16'hC3D2,16'h0000,1'b0,19'h00008,2'b01,16'h0000,19'h00000,2'b00,16'h0000,16'h00C3},
      '{1'b1,1'b1,20'h2000A,16'hCAFE,2'd3,16'h0000,16'h0000,1'b0,19'h10005,2'b00,16'hCAFE,19'h00000,2'b00,16'h0000,16'h0000},
      '{1'b0,1'b1,20'h2000A,16'h0000,2'd1,16'h8421,16'h0000,1'b0,19'h10005,2'b00,16'h0000,19'h00000,2'b00,16'h0000,16'h8421},
      '{1'b1,1'b1,20'h00101,16'h5AA5,2'd0,16'h0000,16'h0000,1'b1,19'h00080,2'b01,16'hA500,19'h00081,2'b10,16'h005A,16'h0000},
      '{1'b0,1'b1,20'h00101,16'h0000,2'd2,16'h7713,16'h99EE,1'b1,19'h00080,2'b01,16'h0000,19'h00081,2'b10,16'h0000,16'hEE77},
      '{1'b1,1'b1,20'hFFFFF,16'h1357,2'd1,16'h0000,16'h0000,1'b1,19'h7FFFF,2'b01,16'h5700,19'h00000,2'b10,16'h0013,16'h0000},
      '{1'b0,1'b1,20'hFFFFF,16'h0000,2'd0,16'hAB00,16'h00CD,1'b1,19'h7FFFF,2'b01,16'h0000,19'h00000,2'b10,16'h0000,16'hCDAB}
   };

   int n_chk = 0;
   int n_bad = 0;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   function automatic string tag_of(input vec_t v);
      if (!v.wd) return v.addr[0] ? "R3" : "R2";
      if (!v.addr[0]) return "R4";
      return (v.addr == 20'hFFFFF) ? "R6" : "R5";
   endfunction

   task automatic run_vec(input vec_t v);
      string t;
      t = tag_of(v);
      @(negedge clk);
      req_valid = 1'b1;
      req_write = v.wr;
      req_word  = v.wd;
      req_addr  = v.addr;
      req_wdata = v.wdata;
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 0; k < (v.two ? 2 : 1); k++) begin
         chk((k == 0) ? "R8" : "R5", "bus_cyc", {31'd0, bus_cyc}, 32'd1);
         chk(t, "bus_addr", {13'd0, bus_addr}, {13'd0, (k == 0) ? v.ea1 : v.ea2});
         chk("R7", "lane enables", {30'd0, bus_bhe_n, bus_a0}, {30'd0, (k == 0) ? v.el1 : v.el2});
         chk("R12", "bus_we", {31'd0, bus_we}, {31'd0, v.wr});
         if (v.wr) chk(t, "bus_wdata", {16'd0, bus_wdata}, {16'd0, (k == 0) ? v.ew1 : v.ew2});
         bus_rdata = (k == 0) ? v.rd1 : v.rd2;
         for (int w = 0; w < int'(v.waits); w++) begin
            @(negedge clk);
            chk("R8", "held addr", {12'd0, bus_cyc, bus_addr}, {12'd0, 1'b1, (k == 0) ? v.ea1 : v.ea2});
         end
         bus_ready = 1'b1;
         @(negedge clk);
         bus_ready = 1'b0;
         if (k == 0 && v.two) chk("R9", "done mid-split", {31'd0, done}, 32'd0);
      end
      chk("R9", "done", {31'd0, done}, 32'd1);
      chk("R9", "bus_cyc after last", {31'd0, bus_cyc}, 32'd0);
      if (!v.wr) chk("R10", "rdata", {16'd0, rdata}, {16'd0, v.erd});
      @(negedge clk);
      chk("R9", "done width", {31'd0, done}, 32'd0);
   endtask

   initial begin
      #400000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      report();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "busy in reset", {31'd0, busy}, 32'd0);
      chk("R1", "done in reset", {31'd0, done}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "bus_cyc after reset", {31'd0, bus_cyc}, 32'd0);
      chk("R1", "busy after reset", {31'd0, busy}, 32'd0);

      foreach (VECS[i]) run_vec(VECS[i]);

      // R11: request during a held cycle must not start another transfer
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_word = 1'b0;
      req_addr = 20'h00002; req_wdata = '0;
      @(negedge clk);
      req_addr = 20'h00005; req_word = 1'b1; req_write = 1'b1;
      bus_rdata = 16'h3C11;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R11", "addr during busy", {13'd0, bus_addr}, 32'h1);
      chk("R11", "we during busy", {31'd0, bus_we}, 32'd0);
      bus_ready = 1'b1;
      @(negedge clk);
      bus_ready = 1'b0;
      chk("R10", "rdata byte", {16'd0, rdata}, 32'h0011);
      for (int j = 0; j < 3; j++) begin
         @(negedge clk);
         chk("R11", "no extra cycle", {30'd0, bus_cyc, busy}, 32'd0);
      end

      report();
      $finish;
   end
endmodule